// File: doc/BRIEF.md
# Dual-Codeword Pair-Interleaved Memory ECC

This block guards a 128-bit data word that is written across two memory channels running in lockstep. The encoder splits the word into two independent halves. Each half is coded into a 72-bit codeword: 64 data bits and 8 check bits. The two codewords are merged into a 144-bit storage word. The merge takes two bits from one codeword, then two bits from the other, and repeats. The redundancy is 12.5%.

The decoder reverses the merge and computes an 8-bit syndrome for each codeword. It then repairs whatever the code can repair. The code repairs any one flipped bit, and any aligned pair of flipped bits, within one codeword. Because the two codewords are woven in pairs, a short burst of upsets in storage becomes a small, correctable error in each codeword. This covers a contiguous run of two or three stored bits, or a whole 4-bit device slice. Each codeword reports its own flags: one for "repaired" and one for "could not repair".

Both paths are combinational. A parameter adds one register stage on the outputs, and by default that stage is present.

Top module: `dual_cw_ecc`

## Requirements
- R1: Data bits [63:0] form codeword 0 and bits [127:64] form codeword 1. In each 72-bit codeword, positions 0, 1, 2, 4, 8, 16, 32 and 64 hold the check bits. The 64 data bits fill the other positions in ascending order, so data bit 0 of a codeword sits at position 3 and data bit 2 sits at position 6.
- R2: Codeword c, position p is stored at index 4*(p/2) + 2*c + (p mod 2). For example, write bit 0 lands on stored bit 5 and write bit 64 lands on stored bit 7.
- R3: The parity-check column of position p is built from m = p/2. For even p, its low 7 bits are {0, m}. For odd p, they are {1, m·x in GF(64) mod x^6+x+1}. Bit 7 makes the column weight odd. The code is linear, so an all-zero write encodes to an all-zero storage word.
- R4: Reading back an unaltered storage word returns the written data with all four flags clear.
- R5: Any single flipped stored bit is repaired. The "repaired" flag is raised only for the codeword that owns that bit, and no "could not repair" flag is raised.
- R6: Any burst of two adjacent flipped stored bits is repaired. "Repaired" is raised for exactly the codewords touched.
- R7: Any burst of three adjacent flipped stored bits is repaired. "Repaired" is raised for exactly the codewords touched.
- R8: Flipping any aligned 4-bit slice (stored bits 4k to 4k+3) is repaired, and both "repaired" flags are raised.
- R9: A nonzero syndrome that matches no single or aligned-pair pattern raises that codeword's "could not repair" flag and passes its data bits through unchanged. One example is two flips at even positions of different pairs, such as positions 6 and 10.
- R10: With the output stage present, results appear one clock after the inputs. A synchronous active-low reset clears every output to zero.
- R11: A codeword never raises "repaired" and "could not repair" together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 128 | Data word to encode |
| wr_code | output | 144 | Interleaved storage word |
| rd_code | input | 144 | Storage word read back |
| rd_data | output | 128 | Repaired data word |
| rd_fixed | output | 2 | Per-codeword "repaired" flag |
| rd_fail | output | 2 | Per-codeword "could not repair" flag |

## Verification
A wrong column table, lane map or flip mask is visible at the ports. It shows as a data mismatch on the first read after an injection of the affected pattern, one clock later. It can also show as a flag on the wrong codeword. Every single-bit, two-bit, three-bit and aligned-slice position is swept over several data words, so a fault confined to one position cannot stay hidden. A mix-up in flag logic also shows up as a raised flag on clean reads. A mix-up in the pass-through of data shows up as changed data on deliberately uncorrectable reads.

// File: rtl/ecc_pkg.sv
// Shared widths and code-construction functions for the dual-codeword ECC.
// Assumes 8 check bits per codeword and at most 64 column pairs.
package ecc_pkg;
    parameter int N_CW      = 2;
    parameter int CW_DATA_W = 64;
    parameter int CW_CHK_W  = 8;
    parameter int LANE_W    = 2;
    parameter int CW_W      = CW_DATA_W + CW_CHK_W;
    parameter int CW_PAIRS  = CW_W / LANE_W;
    parameter int DATA_W    = N_CW * CW_DATA_W;
    parameter int STORE_W   = N_CW * CW_W;

    // Multiply by x in GF(64), polynomial x^6 + x + 1.
    function automatic logic [5:0] gf_xtime(logic [5:0] v);
        return {v[4:0], 1'b0} ^ (v[5] ? 6'b000011 : 6'b000000);
    endfunction

    // Parity-check column for codeword position p (odd weight, pair-distinct).
    function automatic logic [CW_CHK_W-1:0] h_col(int p);
        logic [5:0] m;
        logic [6:0] lo;
        m  = 6'(p / 2);
        lo = (p % 2 == 0) ? {1'b0, m} : {1'b1, gf_xtime(m)};
        return {~(^lo), lo};
    endfunction

    // Position of the check bit whose column is the unit vector e_k.
    function automatic int chk_pos(int k);
        if (k < 6) return 2 << k;
        if (k == 6) return 1;
        return 0;
    endfunction

    function automatic bit is_chk(int p);
        for (int k = 0; k < CW_CHK_W; k++)
            if (chk_pos(k) == p) return 1'b1;
        return 1'b0;
    endfunction

    // Codeword position of the i-th data bit.
    function automatic int data_pos(int i);
        int n;
        n = 0;
        for (int p = 0; p < CW_W; p++) begin
            if (!is_chk(p)) begin
                if (n == i) return p;
                n++;
            end
        end
        return 0;
    endfunction

    // Storage index of codeword c, position p (pair interleave).
    function automatic int store_idx(int c, int p);
        return LANE_W * N_CW * (p / LANE_W) + LANE_W * c + (p % LANE_W);
    endfunction
endpackage

// File: rtl/cw_encoder.sv
// Encodes one 64-bit data slice into a 72-bit codeword.
// Assumes each check position carries a unit-vector column, so the
// check bits are simply the XOR of the data columns.
module cw_encoder
    import ecc_pkg::*;
(
    input  logic [CW_DATA_W-1:0] data_in,
    output logic [CW_W-1:0]      cw_out
);
    logic [CW_CHK_W-1:0] chk;
    wire  [CW_W-1:0]     cw_w;

    // Accumulate the columns of every set data bit.
    always_comb begin
        chk = '0;
        for (int i = 0; i < CW_DATA_W; i++)
            if (data_in[i]) chk ^= h_col(data_pos(i));
    end

    for (genvar i = 0; i < CW_DATA_W; i++) begin : g_data
        localparam int DP = data_pos(i);
        assign cw_w[DP] = data_in[i];
    end

    for (genvar k = 0; k < CW_CHK_W; k++) begin : g_chk
        localparam int CP = chk_pos(k);
        assign cw_w[CP] = chk[k];
    end

    assign cw_out = cw_w;
endmodule

// File: rtl/cw_decoder.sv
// Computes one codeword's syndrome and repairs a single flip or an
// aligned pair of flips. Assumes the columns from ecc_pkg::h_col: odd
// weight for singles, so pair syndromes (even weight) never alias them.
module cw_decoder
    import ecc_pkg::*;
(
    input  logic [CW_W-1:0]      cw_in,
    output logic [CW_DATA_W-1:0] data_out,
    output logic                 fixed,
    output logic                 fail
);
    logic [CW_CHK_W-1:0] syn;
    logic [CW_W-1:0]     hit_one;
    logic [CW_PAIRS-1:0] hit_two;
    logic [CW_W-1:0]     flip;
    logic [CW_W-1:0]     repaired;
    logic                matched;

    // Syndrome: XOR of the columns of every set bit.
    always_comb begin
        syn = '0;
        for (int p = 0; p < CW_W; p++)
            if (cw_in[p]) syn ^= h_col(p);
    end

    // Match the syndrome against every single and aligned-pair pattern.
    always_comb begin
        for (int p = 0; p < CW_W; p++)
            hit_one[p] = (syn == h_col(p));
        for (int m = 0; m < CW_PAIRS; m++)
            hit_two[m] = (syn == (h_col(2 * m) ^ h_col(2 * m + 1)));
    end

    // Build the flip mask and the repair verdict.
    always_comb begin
        for (int p = 0; p < CW_W; p++)
            flip[p] = hit_one[p] | hit_two[p / 2];
        matched  = (|hit_one) | (|hit_two);
        repaired = cw_in ^ flip;
        fixed    = matched;
        fail     = (syn != '0) && !matched;
    end

    for (genvar i = 0; i < CW_DATA_W; i++) begin : g_out
        localparam int DP = data_pos(i);
        assign data_out[i] = repaired[DP];
    end
endmodule

// File: rtl/pair_lane_map.sv
// Moves bits between codeword order (codeword c at c*CW_W) and storage
// order. TO_STORE picks the direction; the map is pure wiring.
module pair_lane_map
    import ecc_pkg::*;
#(
    parameter bit TO_STORE = 1'b1
) (
    input  logic [STORE_W-1:0] bits_in,
    output logic [STORE_W-1:0] bits_out
);
    wire [STORE_W-1:0] map_w;

    for (genvar c = 0; c < N_CW; c++) begin : g_cw
        for (genvar p = 0; p < CW_W; p++) begin : g_pos
            localparam int SI = store_idx(c, p);
            localparam int CI = c * CW_W + p;
            if (TO_STORE) begin : g_fwd
                assign map_w[SI] = bits_in[CI];
            end else begin : g_rev
                assign map_w[CI] = bits_in[SI];
            end
        end
    end

    assign bits_out = map_w;
endmodule

// File: rtl/dual_cw_ecc.sv
// Top: two (72,64) codes, pair-interleaved into a 144-bit storage word.
// Assumes the read word comes from a write of this block. OUT_REG adds
// one output register stage with a synchronous active-low reset.
module dual_cw_ecc
    import ecc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [STORE_W-1:0] wr_code,
    input  logic [STORE_W-1:0] rd_code,
    output logic [DATA_W-1:0]  rd_data,
    output logic [N_CW-1:0]    rd_fixed,
    output logic [N_CW-1:0]    rd_fail
);
    logic [STORE_W-1:0] enc_cw;
    logic [STORE_W-1:0] enc_store;
    logic [STORE_W-1:0] dec_cw;
    logic [DATA_W-1:0]  dec_data;
    logic [N_CW-1:0]    dec_fixed;
    logic [N_CW-1:0]    dec_fail;

    for (genvar c = 0; c < N_CW; c++) begin : g_lane
        cw_encoder u_enc (
            .data_in (wr_data[c*CW_DATA_W +: CW_DATA_W]),
            .cw_out  (enc_cw[c*CW_W +: CW_W])
        );
        cw_decoder u_dec (
            .cw_in    (dec_cw[c*CW_W +: CW_W]),
            .data_out (dec_data[c*CW_DATA_W +: CW_DATA_W]),
            .fixed    (dec_fixed[c]),
            .fail     (dec_fail[c])
        );
    end

    pair_lane_map #(.TO_STORE(1'b1)) u_scatter (
        .bits_in  (enc_cw),
        .bits_out (enc_store)
    );

    pair_lane_map #(.TO_STORE(1'b0)) u_gather (
        .bits_in  (rd_code),
        .bits_out (dec_cw)
    );

    if (OUT_REG) begin : g_reg
        // Register both paths; reset clears every output.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wr_code  <= '0;
                rd_data  <= '0;
                rd_fixed <= '0;
                rd_fail  <= '0;
            end else begin
                wr_code  <= enc_store;
                rd_data  <= dec_data;
                rd_fixed <= dec_fixed;
                rd_fail  <= dec_fail;
            end
        end
    end else begin : g_comb
        assign wr_code  = enc_store;
        assign rd_data  = dec_data;
        assign rd_fixed = dec_fixed;
        assign rd_fail  = dec_fail;
    end
endmodule

// File: rtl/dual_cw_ecc_chk.sv
// Port-level checker for dual_cw_ecc with its output stage present.
module dual_cw_ecc_chk
    import ecc_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  wr_data,
    input logic [STORE_W-1:0] wr_code,
    input logic [STORE_W-1:0] rd_code,
    input logic [DATA_W-1:0]  rd_data,
    input logic [N_CW-1:0]    rd_fixed,
    input logic [N_CW-1:0]    rd_fail
);
    logic [1:0] live;

    // Count clean cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= '0;
        else if (live != 2'd3) live <= live + 2'd1;
    end

    if (OUT_REG) begin : g_props
        // R4: an untouched read returns the data written two cycles back.
        a_r4_clean_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
            (live >= 2'd2 && rd_code == wr_code) |=>
            (rd_data == $past(wr_data, 2) && rd_fixed == '0 && rd_fail == '0));

        // R5: one flipped bit is repaired in exactly one codeword.
        a_r5_single_repaired: assert property (@(posedge clk) disable iff (!rst_n)
            (live >= 2'd2 && $onehot(rd_code ^ wr_code)) |=>
            (rd_data == $past(wr_data, 2) && rd_fail == '0 && $countones(rd_fixed) == 1));

        // R3: zero data encodes to a zero storage word.
        a_r3_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_data == '0) |=> (wr_code == '0));

        // R11: no codeword reports repaired and failed together.
        a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_fixed & rd_fail) == '0));

        // R9: a failure flag never follows an untouched read.
        a_r9_fail_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
            (live >= 2'd3 && rd_fail != '0) |-> ($past(rd_code) != $past(wr_code)));
    end
endmodule

bind dual_cw_ecc dual_cw_ecc_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (wr_data),
    .wr_code  (wr_code),
    .rd_code  (rd_code),
    .rd_data  (rd_data),
    .rd_fixed (rd_fixed),
    .rd_fail  (rd_fail)
);

// File: tb/test_dual_cw_ecc.sv
// Scoreboard bench: the driver queues expected read results, the monitor
// compares them one clock after the read word is applied.
module test_dual_cw_ecc;
    import ecc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [DATA_W-1:0] data;
        logic [N_CW-1:0]   fixed;
        logic [N_CW-1:0]   fail;
        string             tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [STORE_W-1:0] rd_code = '0;
    logic [STORE_W-1:0] wr_code;
    logic [DATA_W-1:0]  rd_data;
    logic [N_CW-1:0]    rd_fixed;
    logic [N_CW-1:0]    rd_fail;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_cw_ecc i_dual_cw_ecc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_code  (wr_code),
        .rd_code  (rd_code),
        .rd_data  (rd_data),
        .rd_fixed (rd_fixed),
        .rd_fail  (rd_fail)
    );

    task automatic check(bit ok, string tag, logic [DATA_W+3:0] act, logic [DATA_W+3:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Codewords touched by an error vector (stored pairs alternate owners).
    function automatic logic [N_CW-1:0] touched(logic [STORE_W-1:0] e);
        logic [N_CW-1:0] t;
        t = '0;
        for (int j = 0; j < STORE_W; j++)
            if (e[j]) t[(j / 2) % N_CW] = 1'b1;
        return t;
    endfunction

    task automatic encode(logic [DATA_W-1:0] d, output logic [STORE_W-1:0] code);
        @(negedge clk);
        wr_data = d;
        @(posedge clk);
        #1;
        code = wr_code;
    endtask

    task automatic drive_read(logic [STORE_W-1:0] code, logic [DATA_W-1:0] d,
                              logic [N_CW-1:0] fx, logic [N_CW-1:0] fl, string tag);
        exp_t e;
        @(negedge clk);
        rd_code = code;
        e.data = d; e.fixed = fx; e.fail = fl; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare one queued expectation per clock.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(rd_data == e.data && rd_fixed == e.fixed && rd_fail == e.fail, e.tag,
                      {rd_data, rd_fixed, rd_fail}, {e.data, e.fixed, e.fail});
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [STORE_W-1:0] code;
        logic [DATA_W-1:0]  d;
        logic [STORE_W-1:0] e;
        logic [DATA_W-1:0]  pats [3];
        pats[0] = '0;
        pats[1] = '1;
        pats[2] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;

        // R10: reset clears all outputs despite active inputs.
        wr_data = '1;
        rd_code = '1;
        repeat (3) @(posedge clk);
        #1;
        check(wr_code == '0 && rd_data == '0 && rd_fixed == '0 && rd_fail == '0,
              "R10 reset clears outputs", {rd_data, rd_fixed, rd_fail}, '0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_code = '0;

        // R3: zero encodes to zero.
        encode('0, code);
        check(code == '0, "R3 zero encodes to zero", code[DATA_W+3:0], '0);

        // R1, R2: data bit 0 of each codeword lands on stored bits 5 and 7.
        encode(128'd1, code);
        check(code[5] == 1'b1 && code[7] == 1'b0, "R1 R2 bit0 lane0 at stored 5",
              code[DATA_W+3:0], 132'h20);
        d = '0;
        d[64] = 1'b1;
        encode(d, code);
        check(code[7] == 1'b1 && code[5] == 1'b0, "R2 bit64 lane1 at stored 7",
              code[DATA_W+3:0], 132'h80);

        foreach (pats[n]) begin
            d = pats[n];
            encode(d, code);
            drive_read(code, d, 2'b00, 2'b00, "R4 clean read");
            for (int j = 0; j < STORE_W; j++) begin
                e = '0; e[j] = 1'b1;
                drive_read(code ^ e, d, touched(e), 2'b00, "R5 single flip");
            end
            for (int j = 0; j < STORE_W - 1; j++) begin
                e = '0; e[j +: 2] = 2'b11;
                drive_read(code ^ e, d, touched(e), 2'b00, "R6 2-bit burst");
            end
            for (int j = 0; j < STORE_W - 2; j++) begin
                e = '0; e[j +: 3] = 3'b111;
                drive_read(code ^ e, d, touched(e), 2'b00, "R7 3-bit burst");
            end
            for (int k = 0; k < STORE_W / 4; k++) begin
                e = '0; e[4 * k +: 4] = 4'hF;
                drive_read(code ^ e, d, 2'b11, 2'b00, "R8 4-bit slice");
            end
            // R9: positions 6 and 10 (data bits 2 and 5) of each codeword.
            e = '0; e[12] = 1'b1; e[20] = 1'b1;
            drive_read(code ^ e, d ^ (128'd1 << 2) ^ (128'd1 << 5), 2'b00, 2'b01,
                       "R9 R11 uncorrectable lane0");
            e = '0; e[14] = 1'b1; e[22] = 1'b1;
            drive_read(code ^ e, d ^ (128'd1 << 66) ^ (128'd1 << 69), 2'b00, 2'b10,
                       "R9 R11 uncorrectable lane1");
            drive_read(code, d, 2'b00, 2'b00, "R4 R11 clean after fail");
        end

        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule